// File: doc/BRIEF.md
# Counter Event Selector Register File with Overflow Summary

This block keeps the event selector registers of the programmable hardware performance counters (indices 3 to 31) on behalf of a processor's control and status register (CSR) unit. Each counter owns a selector that is a full 64-bit word in 64-bit mode. In 32-bit mode the selector is split into a low word and a separate high word, each with its own CSR address. Counting and event decoding live elsewhere. This block only stores the selectors. Whenever either word is written, it emits a one-cycle pulse that carries the counter index and the complete 64-bit selector value. An external event-mapping unit uses that pulse to reconfigure itself.

The most significant bit of each 64-bit selector is that counter's overflow flag. The block gathers these flags into a read-only supervisor summary word. A flag appears there only when the machine-level counter-enable mask grants lower privilege levels access to that counter. The block also holds the local counter-overflow interrupt pending bit. Supervisor software can set and clear it through the supervisor interrupt-pending CSR. The high selector words, the summary word and the pending bit are all governed by an overflow-extension enable input.

CSR accesses are single-cycle. Read data and the illegal-access flag are combinational from the address presented. A legal write takes effect at the next rising clock edge.

Top module: `evt_regfile`

## Requirements
- R1: While reset is high and after it, every selector word, the summary word, the pending bit and the update pulse are zero. The update pulse is only ever high in the cycle after a write request.
- R2: A legal write to a low-word address (low base 0x320 + n, n in 3..31) in 64-bit mode stores all 64 bits. At the write edge, the update pulse rises for exactly one cycle with index n and the written 64-bit value. A read in 64-bit mode returns the stored 64 bits.
- R3: In 32-bit mode, a low-word write stores only wdata[31:0]. The pulse value is {stored high word, wdata[31:0]}. A read returns the low 32 bits, zero-extended.
- R4: In 32-bit mode with the extension enabled, a write to high-word address 0x720 + n stores wdata[31:0] as the high word. The pulse value is {wdata[31:0], stored low word[31:0]}. A read returns the high word, zero-extended.
- R5: A high-word access is illegal when the extension is disabled or the mode is 64-bit. The access raises csr_illegal. Read data is zero, and a write changes no stored state and produces no pulse.
- R6: summary_o bit n (n from 3 to 31) equals mcounteren[n] AND the overflow flag of counter n. The flag is bit 31 of the high word in 32-bit mode and bit 63 of the 64-bit word in 64-bit mode. Bits 0 to 2 are always zero.
- R7: Reading the summary address 0xDA0 returns summary_o, zero-extended. Such a read is illegal with zero data when the extension is disabled. Any write to it is illegal and has no effect.
- R8: The pending bit sits at bit 13 of the supervisor interrupt-pending address 0x144. With the extension enabled, a write loads that bit from wdata[13] and a read returns it in bit 13 with all other bits zero. With the extension disabled, writes leave it unchanged and reads return zero.
- R9: Offsets 0 to 2 from the low base are not decoded. An access there is not illegal, returns zero data and produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rv32_mode | input | 1 | 1 = 32-bit register width, 0 = 64-bit |
| ovf_ext_en | input | 1 | Overflow extension enable |
| mcounteren | input | 32 | Machine counter-enable mask for lower privilege |
| csr_req | input | 1 | CSR access request |
| csr_we | input | 1 | Access is a write |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | 64 | Write data |
| csr_rdata | output | 64 | Read data (combinational) |
| csr_illegal | output | 1 | Access is illegal (combinational) |
| evt_upd_valid | output | 1 | One-cycle selector update pulse |
| evt_upd_idx | output | 5 | Counter index of the update |
| evt_upd_value | output | 64 | Merged 64-bit selector value |
| summary_o | output | 32 | Overflow summary word |
| lcof_pending | output | 1 | Local counter-overflow interrupt pending |

## Verification
The bench builds the block with its default parameters: 32 counters, the first selector at index 3, and the standard CSR addresses. With these values it can reach index 31, which is the top edge of the decoded window, and the undecoded offsets 0 to 2 just below index 3. The same stored selectors are read in both register widths. This shows the overflow flag moving between the high word and bit 63, and it shows the merge picking up a high word that was written earlier.

// File: rtl/pmu_evt_pkg.sv
package pmu_evt_pkg;

    localparam int CTR_MAX   = 32;
    localparam int CTR_IDX_W = $clog2(CTR_MAX);
    localparam int DATA_W    = 64;
    localparam int HALF_W    = DATA_W / 2;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_EVT_LO,
        ACC_EVT_HI,
        ACC_SUMMARY,
        ACC_SIP
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e              kind;
        logic [CTR_IDX_W-1:0]   idx;
        logic                   illegal;
    } acc_dec_t;

    typedef struct packed {
        logic [DATA_W-1:0]      lo;
        logic [HALF_W-1:0]      hi;
    } evt_pair_t;

    // 64-bit selector image that results from a write to one of the halves
    function automatic logic [DATA_W-1:0] merge_write(
        input logic              narrow,
        input logic              to_high,
        input logic [DATA_W-1:0] wdata,
        input evt_pair_t         cur
    );
        if (to_high)
            return {wdata[HALF_W-1:0], cur.lo[HALF_W-1:0]};
        else if (narrow)
            return {cur.hi, wdata[HALF_W-1:0]};
        else
            return wdata;
    endfunction

    // Overflow flag: top bit of the 64-bit image, held in the high word when narrow
    function automatic logic ovf_flag(input logic narrow, input evt_pair_t cur);
        return narrow ? cur.hi[HALF_W-1] : cur.lo[DATA_W-1];
    endfunction

    function automatic logic [DATA_W-1:0] read_low(input logic narrow, input evt_pair_t cur);
        return narrow ? {{HALF_W{1'b0}}, cur.lo[HALF_W-1:0]} : cur.lo;
    endfunction

endpackage

// File: rtl/evt_csr_decode.sv
module evt_csr_decode
    import pmu_evt_pkg::*;
#(
    parameter int          FIRST_CTR = 3,
    parameter int          NUM_CTR   = 32,
    parameter logic [11:0] LO_BASE   = 12'h320,
    parameter logic [11:0] HI_BASE   = 12'h720,
    parameter logic [11:0] SUM_ADDR  = 12'hDA0,
    parameter logic [11:0] SIP_ADDR  = 12'h144
) (
    input  logic        narrow,
    input  logic        ext_en,
    input  logic        is_write,
    input  logic [11:0] addr,
    output acc_dec_t    dec
);
    localparam logic [11:0] OFF_MIN = 12'(FIRST_CTR);
    localparam logic [11:0] OFF_MAX = 12'(NUM_CTR);

    logic [11:0] off_lo;
    logic [11:0] off_hi;

    always_comb begin
        off_lo = addr - LO_BASE;
        off_hi = addr - HI_BASE;
        dec    = '{kind: ACC_NONE, idx: '0, illegal: 1'b0};
        if (addr == SUM_ADDR) begin
            dec.kind    = ACC_SUMMARY;
            dec.illegal = !ext_en || is_write;
        end else if (addr == SIP_ADDR) begin
            dec.kind = ACC_SIP;
        end else if (off_lo >= OFF_MIN && off_lo < OFF_MAX) begin
            dec.kind = ACC_EVT_LO;
            dec.idx  = off_lo[CTR_IDX_W-1:0];
        end else if (off_hi >= OFF_MIN && off_hi < OFF_MAX) begin
            dec.kind    = ACC_EVT_HI;
            dec.idx     = off_hi[CTR_IDX_W-1:0];
            dec.illegal = !ext_en || !narrow;
        end
    end
endmodule

// File: rtl/evt_slot.sv
module evt_slot
    import pmu_evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              narrow,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wdata,
    output evt_pair_t         pair_q,
    output logic [DATA_W-1:0] merged_o,
    output logic              flag_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pair_q <= '0;
        end else if (wr_lo) begin
            pair_q.lo <= narrow ? {{HALF_W{1'b0}}, wdata[HALF_W-1:0]} : wdata;
        end else if (wr_hi) begin
            pair_q.hi <= wdata[HALF_W-1:0];
        end
    end

    assign merged_o = merge_write(narrow, wr_hi, wdata, pair_q);
    assign flag_o   = ovf_flag(narrow, pair_q);
endmodule

// File: rtl/ovf_summary.sv
module ovf_summary #(
    parameter int FIRST_CTR = 3,
    parameter int NUM_CTR   = 32
) (
    input  logic [NUM_CTR-1:0] flags,
    input  logic [NUM_CTR-1:0] enable_mask,
    output logic [NUM_CTR-1:0] summary
);
    for (genvar i = 0; i < NUM_CTR; i++) begin : g_bit
        if (i < FIRST_CTR) begin : g_fixed
            assign summary[i] = 1'b0;
        end else begin : g_live
            assign summary[i] = flags[i] & enable_mask[i];
        end
    end
endmodule

// File: rtl/evt_regfile.sv
module evt_regfile
    import pmu_evt_pkg::*;
#(
    parameter int          FIRST_CTR = 3,
    parameter int          NUM_CTR   = CTR_MAX,
    parameter int          LCOF_BIT  = 13,
    parameter logic [11:0] LO_BASE   = 12'h320,
    parameter logic [11:0] HI_BASE   = 12'h720,
    parameter logic [11:0] SUM_ADDR  = 12'hDA0,
    parameter logic [11:0] SIP_ADDR  = 12'h144
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rv32_mode,
    input  logic                 ovf_ext_en,
    input  logic [NUM_CTR-1:0]   mcounteren,
    input  logic                 csr_req,
    input  logic                 csr_we,
    input  logic [11:0]          csr_addr,
    input  logic [DATA_W-1:0]    csr_wdata,
    output logic [DATA_W-1:0]    csr_rdata,
    output logic                 csr_illegal,
    output logic                 evt_upd_valid,
    output logic [CTR_IDX_W-1:0] evt_upd_idx,
    output logic [DATA_W-1:0]    evt_upd_value,
    output logic [NUM_CTR-1:0]   summary_o,
    output logic                 lcof_pending
);
    localparam int SUM_PAD = DATA_W - NUM_CTR;

    acc_dec_t          dec;
    logic              wr_ok;
    logic              wr_lo_any;
    logic              wr_hi_any;
    evt_pair_t         pair_arr   [NUM_CTR];
    logic [DATA_W-1:0] merged_arr [NUM_CTR];
    logic [NUM_CTR-1:0] flag_vec;

    evt_csr_decode #(
        .FIRST_CTR(FIRST_CTR), .NUM_CTR(NUM_CTR),
        .LO_BASE(LO_BASE), .HI_BASE(HI_BASE),
        .SUM_ADDR(SUM_ADDR), .SIP_ADDR(SIP_ADDR)
    ) u_dec (
        .narrow  (rv32_mode),
        .ext_en  (ovf_ext_en),
        .is_write(csr_we),
        .addr    (csr_addr),
        .dec     (dec)
    );

    assign wr_ok     = csr_req && csr_we && !dec.illegal;
    assign wr_lo_any = wr_ok && (dec.kind == ACC_EVT_LO);
    assign wr_hi_any = wr_ok && (dec.kind == ACC_EVT_HI);

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
        if (i < FIRST_CTR) begin : g_absent
            assign pair_arr[i]   = '0;
            assign merged_arr[i] = '0;
            assign flag_vec[i]   = 1'b0;
        end else begin : g_slot
            logic sel;
            assign sel = (dec.idx == CTR_IDX_W'(i));
            evt_slot u_slot (
                .clk     (clk),
                .rst     (rst),
                .narrow  (rv32_mode),
                .wr_lo   (wr_lo_any && sel),
                .wr_hi   (wr_hi_any && sel),
                .wdata   (csr_wdata),
                .pair_q  (pair_arr[i]),
                .merged_o(merged_arr[i]),
                .flag_o  (flag_vec[i])
            );
        end
    end

    ovf_summary #(.FIRST_CTR(FIRST_CTR), .NUM_CTR(NUM_CTR)) u_sum (
        .flags      (flag_vec),
        .enable_mask(mcounteren),
        .summary    (summary_o)
    );

    // Update pulse toward the event-mapping unit
    always_ff @(posedge clk) begin
        if (rst) begin
            evt_upd_valid <= 1'b0;
            evt_upd_idx   <= '0;
            evt_upd_value <= '0;
        end else begin
            evt_upd_valid <= wr_lo_any || wr_hi_any;
            if (wr_lo_any || wr_hi_any) begin
                evt_upd_idx   <= dec.idx;
                evt_upd_value <= merged_arr[dec.idx];
            end
        end
    end

    // Local counter-overflow interrupt pending bit
    always_ff @(posedge clk) begin
        if (rst)
            lcof_pending <= 1'b0;
        else if (wr_ok && dec.kind == ACC_SIP && ovf_ext_en)
            lcof_pending <= csr_wdata[LCOF_BIT];
    end

    always_comb begin
        csr_rdata   = '0;
        csr_illegal = csr_req && dec.illegal;
        if (!dec.illegal) begin
            unique case (dec.kind)
                ACC_EVT_LO:  csr_rdata = read_low(rv32_mode, pair_arr[dec.idx]);
                ACC_EVT_HI:  csr_rdata = {{HALF_W{1'b0}}, pair_arr[dec.idx].hi};
                ACC_SUMMARY: csr_rdata = {{SUM_PAD{1'b0}}, summary_o};
                ACC_SIP:     csr_rdata[LCOF_BIT] = lcof_pending && ovf_ext_en;
                default:     csr_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/evt_regfile_chk.sv
module evt_regfile_chk
    import pmu_evt_pkg::*;
#(
    parameter int          FIRST_CTR = 3,
    parameter int          NUM_CTR   = CTR_MAX,
    parameter logic [11:0] LO_BASE   = 12'h320,
    parameter logic [11:0] HI_BASE   = 12'h720,
    parameter logic [11:0] SUM_ADDR  = 12'hDA0
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 ovf_ext_en,
    input logic [NUM_CTR-1:0]   mcounteren,
    input logic                 csr_req,
    input logic                 csr_we,
    input logic [11:0]          csr_addr,
    input logic [DATA_W-1:0]    csr_rdata,
    input logic                 csr_illegal,
    input logic                 evt_upd_valid,
    input logic [CTR_IDX_W-1:0] evt_upd_idx,
    input logic [NUM_CTR-1:0]   summary_o,
    input logic                 lcof_pending
);
    logic [11:0] lo_off;
    logic [11:0] hi_off;
    logic        ev_hit;
    logic [CTR_IDX_W-1:0] ev_idx;

    always_comb begin
        lo_off = csr_addr - LO_BASE;
        hi_off = csr_addr - HI_BASE;
        ev_hit = 1'b0;
        ev_idx = '0;
        if (lo_off >= 12'(FIRST_CTR) && lo_off < 12'(NUM_CTR)) begin
            ev_hit = 1'b1;
            ev_idx = lo_off[CTR_IDX_W-1:0];
        end else if (hi_off >= 12'(FIRST_CTR) && hi_off < 12'(NUM_CTR)) begin
            ev_hit = 1'b1;
            ev_idx = hi_off[CTR_IDX_W-1:0];
        end
    end

    // R1
    upd_cause_chk: assert property (@(posedge clk) disable iff (rst)
        evt_upd_valid |-> $past(csr_req && csr_we));

    // R2
    upd_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        (csr_req && csr_we && !csr_illegal && ev_hit) |=>
            (evt_upd_valid && evt_upd_idx == $past(ev_idx)));

    // R5
    no_upd_on_illegal_chk: assert property (@(posedge clk) disable iff (rst)
        (csr_req && csr_we && csr_illegal) |=> !evt_upd_valid);

    // R6
    summary_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
        summary_o[FIRST_CTR-1:0] == '0);

    // R6
    summary_masked_chk: assert property (@(posedge clk) disable iff (rst)
        (summary_o & ~mcounteren) == '0);

    // R7
    summary_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (csr_req && csr_addr == SUM_ADDR && (!ovf_ext_en || csr_we)) |-> csr_illegal);

    // R5
    illegal_rdata_zero_chk: assert property (@(posedge clk) disable iff (rst)
        csr_illegal |-> csr_rdata == '0);

    // R8
    lcof_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ovf_ext_en |=> $stable(lcof_pending));
endmodule

bind evt_regfile evt_regfile_chk #(
    .FIRST_CTR(FIRST_CTR), .NUM_CTR(NUM_CTR),
    .LO_BASE(LO_BASE), .HI_BASE(HI_BASE), .SUM_ADDR(SUM_ADDR)
) u_chk (
    .clk(clk), .rst(rst), .ovf_ext_en(ovf_ext_en), .mcounteren(mcounteren),
    .csr_req(csr_req), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_rdata(csr_rdata), .csr_illegal(csr_illegal),
    .evt_upd_valid(evt_upd_valid), .evt_upd_idx(evt_upd_idx),
    .summary_o(summary_o), .lcof_pending(lcof_pending)
);

// File: tb/evt_regfile_test.sv
module evt_regfile_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rv32_mode = 1'b0;
    logic        ovf_ext_en = 1'b1;
    logic [31:0] mcounteren = '1;
    logic        csr_req = 1'b0;
    logic        csr_we = 1'b0;
    logic [11:0] csr_addr = '0;
    logic [63:0] csr_wdata = '0;
    logic [63:0] csr_rdata;
    logic        csr_illegal;
    logic        evt_upd_valid;
    logic [4:0]  evt_upd_idx;
    logic [63:0] evt_upd_value;
    logic [31:0] summary_o;
    logic        lcof_pending;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_regfile uut (
        .clk(clk), .rst(rst), .rv32_mode(rv32_mode), .ovf_ext_en(ovf_ext_en),
        .mcounteren(mcounteren), .csr_req(csr_req), .csr_we(csr_we),
        .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .csr_illegal(csr_illegal), .evt_upd_valid(evt_upd_valid),
        .evt_upd_idx(evt_upd_idx), .evt_upd_value(evt_upd_value),
        .summary_o(summary_o), .lcof_pending(lcof_pending)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic        rv32;
        logic        we;
        logic [11:0] addr;
        logic [63:0] wd;
        logic [63:0] rd;
        logic        ill;
        logic        upd;
        logic [63:0] val;
    } vec_t;

    localparam int NVEC = 13;
    localparam vec_t VECS [NVEC] = '{
        // R2: 64-bit low write, index 5, flag bit 63 set
        '{4'd2, 1'b0, 1'b1, 12'h325, 64'h8000_0000_0000_00A5, 64'h0, 1'b0, 1'b1, 64'h8000_0000_0000_00A5},
        '{4'd2, 1'b0, 1'b0, 12'h325, 64'h0, 64'h8000_0000_0000_00A5, 1'b0, 1'b0, 64'h0},
        // R3: 32-bit low write, index 7
        '{4'd3, 1'b1, 1'b1, 12'h327, 64'hFFFF_FFFF_1234_5678, 64'h0, 1'b0, 1'b1, 64'h0000_0000_1234_5678},
        // R4: high write merges with stored low word
        '{4'd4, 1'b1, 1'b1, 12'h727, 64'h0000_0000_8000_0001, 64'h0, 1'b0, 1'b1, 64'h8000_0001_1234_5678},
        '{4'd4, 1'b1, 1'b0, 12'h727, 64'h0, 64'h0000_0000_8000_0001, 1'b0, 1'b0, 64'h0},
        '{4'd3, 1'b1, 1'b0, 12'h327, 64'h0, 64'h0000_0000_1234_5678, 1'b0, 1'b0, 64'h0},
        // R3: low write picks up the earlier high word
        '{4'd3, 1'b1, 1'b1, 12'h327, 64'h0000_0000_0000_00C3, 64'h0000_0000_1234_5678, 1'b0, 1'b1, 64'h8000_0001_0000_00C3},
        // R5: high word in 64-bit mode is illegal
        '{4'd5, 1'b0, 1'b1, 12'h727, 64'h0000_0000_0000_0001, 64'h0, 1'b1, 1'b0, 64'h0},
        '{4'd5, 1'b1, 1'b0, 12'h727, 64'h0, 64'h0000_0000_8000_0001, 1'b0, 1'b0, 64'h0},
        // R9: offset 2 below the first index is not decoded
        '{4'd9, 1'b1, 1'b1, 12'h322, 64'h5, 64'h0, 1'b0, 1'b0, 64'h0},
        // R3: top index 31
        '{4'd3, 1'b1, 1'b1, 12'h33F, 64'hFFFF_FFFF_AAAA_5555, 64'h0, 1'b0, 1'b1, 64'h0000_0000_AAAA_5555},
        // R7: summary write is illegal
        '{4'd7, 1'b1, 1'b1, 12'hDA0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b1, 1'b0, 64'h0},
        // R2: lowest index 3
        '{4'd2, 1'b0, 1'b1, 12'h323, 64'h1, 64'h0, 1'b0, 1'b1, 64'h1}
    };

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic rv, input logic we, input logic [11:0] a, input logic [63:0] wd,
                          output logic [63:0] rd, output logic ill,
                          output logic upd, output logic [4:0] idx, output logic [63:0] val);
        @(negedge clk);
        rv32_mode = rv; csr_req = 1'b1; csr_we = we; csr_addr = a; csr_wdata = wd;
        #1;
        rd = csr_rdata; ill = csr_illegal;
        @(posedge clk);
        @(negedge clk);
        upd = evt_upd_valid; idx = evt_upd_idx; val = evt_upd_value;
        csr_req = 1'b0; csr_we = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] rd, val;
        logic ill, upd;
        logic [4:0] idx;
        string tag;

        repeat (3) @(negedge clk);
        // R1: reset state, checked while reset is still high
        check(summary_o == 0, "R1 summary in reset", 64'(summary_o), 0);
        check(lcof_pending == 0, "R1 pending in reset", 64'(lcof_pending), 0);
        rst = 1'b0;
        access(1'b0, 1'b0, 12'h325, 0, rd, ill, upd, idx, val);
        check(rd == 0, "R1 selector after reset", rd, 0);
        check(upd == 0, "R1 no pulse after read", 64'(upd), 0);

        for (int k = 0; k < NVEC; k++) begin
            vec_t v;
            v = VECS[k];
            tag = $sformatf("R%0d vec%0d", v.req, k);
            access(v.rv32, v.we, v.addr, v.wd, rd, ill, upd, idx, val);
            check(rd == v.rd, {tag, " rdata"}, rd, v.rd);
            check(ill == v.ill, {tag, " illegal"}, 64'(ill), 64'(v.ill));
            check(upd == v.upd, {tag, " pulse"}, 64'(upd), 64'(v.upd));
            if (v.upd) begin
                check(idx == v.addr[4:0], {tag, " index"}, 64'(idx), 64'(v.addr[4:0]));
                check(val == v.val, {tag, " value"}, val, v.val);
            end
        end

        // R6: 32-bit mode takes flags from high words (index 7 only)
        @(negedge clk); rv32_mode = 1'b1; #1;
        check(summary_o == 32'h80, "R6 summary narrow", 64'(summary_o), 64'h80);
        // R7: summary read
        access(1'b1, 1'b0, 12'hDA0, 0, rd, ill, upd, idx, val);
        check(rd == 64'h80 && !ill, "R7 summary read", rd, 64'h80);
        // R6: 64-bit mode takes bit 63 (index 5 only)
        @(negedge clk); rv32_mode = 1'b0; #1;
        check(summary_o == 32'h20, "R6 summary wide", 64'(summary_o), 64'h20);
        mcounteren = ~32'h20; #1;
        check(summary_o == 0, "R6 summary masked", 64'(summary_o), 0);
        mcounteren = '1;

        // R7: gated by extension enable
        ovf_ext_en = 1'b0;
        access(1'b1, 1'b0, 12'hDA0, 0, rd, ill, upd, idx, val);
        check(ill == 1 && rd == 0, "R7 summary gated", {rd[62:0], ill}, 64'h1);
        // R5: high write with extension disabled is ignored
        access(1'b1, 1'b1, 12'h727, 64'hFFFF_FFFF, rd, ill, upd, idx, val);
        check(ill == 1 && upd == 0, "R5 gated high write", {62'b0, ill, upd}, 64'h2);
        ovf_ext_en = 1'b1;
        access(1'b1, 1'b0, 12'h727, 0, rd, ill, upd, idx, val);
        check(rd == 64'h8000_0001, "R5 high word kept", rd, 64'h8000_0001);

        // R8: pending bit
        access(1'b1, 1'b1, 12'h144, '1, rd, ill, upd, idx, val);
        check(lcof_pending == 1 && upd == 0, "R8 pending set", 64'(lcof_pending), 1);
        access(1'b1, 1'b0, 12'h144, 0, rd, ill, upd, idx, val);
        check(rd == 64'h2000, "R8 pending read", rd, 64'h2000);
        access(1'b1, 1'b1, 12'h144, 0, rd, ill, upd, idx, val);
        check(lcof_pending == 0, "R8 pending clear", 64'(lcof_pending), 0);
        ovf_ext_en = 1'b0;
        access(1'b1, 1'b1, 12'h144, '1, rd, ill, upd, idx, val);
        check(lcof_pending == 0, "R8 disabled write ignored", 64'(lcof_pending), 0);
        access(1'b1, 1'b0, 12'h144, 0, rd, ill, upd, idx, val);
        check(rd == 0, "R8 disabled read zero", rd, 0);
        ovf_ext_en = 1'b1;

        // R1: reset clears stored state again
        access(1'b1, 1'b1, 12'h144, '1, rd, ill, upd, idx, val);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check(lcof_pending == 0, "R1 pending cleared", 64'(lcof_pending), 0);
        access(1'b1, 1'b0, 12'h727, 0, rd, ill, upd, idx, val);
        check(rd == 0, "R1 high word cleared", rd, 0);
        check(summary_o == 0, "R1 summary cleared", 64'(summary_o), 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule